// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns one 64-bit software-generated interrupt request into a series of set-pending strobes, one for each CPU the request selects. A request word comes from a requesting CPU, whose index is given with it. The dispatcher decodes the word and then visits the CPUs in index order, one CPU per clock cycle. Each CPU has a 24-bit affinity value supplied on an input bus. For each CPU the request hits, the block raises a strobe that carries the CPU index and the SGI number. The downstream interrupt state then sets that SGI's pending bit on that CPU.

Targeting works in one of two modes. In targeted mode, a CPU is selected when its upper affinity levels equal the request's levels and its level-0 affinity indexes a set bit in a 16-bit list. A working copy of that list loses each bit as the matching CPU is served, and the scan stops as soon as the copy is empty. In broadcast mode, every CPU except the requester is signalled and the list is ignored. Priority, delivery and acknowledgement are handled elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, busy_o, done_o and set_valid_o are all low.
- R2: The request word is decoded as follows: SGI number in [27:24], level-0 target list in [15:0], level-1 affinity in [23:16], level-2 in [39:32], level-3 in [55:48], and bit 40 selects broadcast (1) or targeted (0). set_sgi_o carries bits [27:24] on every strobe.
- R3: In targeted mode, CPU k is hit only when all of the following hold:
  - the request's level-3 field is zero;
  - the request's level-2 field equals cpu affinity bits [23:16];
  - the request's level-1 field equals cpu affinity bits [15:8];
  - cpu affinity bits [7:4] are zero;
  - the working-list bit indexed by cpu affinity bits [3:0] is set.
- R4: CPUs are visited one per cycle, starting at index 0. The n-th cycle of busy_o (counting from 0) shows CPU n on set_cpu_o, with set_valid_o high if that CPU is hit.
- R5: In targeted mode, each hit clears its bit from the working list. The scan ends on the cycle in which that list becomes zero, including a request whose list is zero from the start, which ends after one cycle.
- R6: In broadcast mode, every CPU whose index differs from req_src_i is hit, whatever the list holds, and the scan covers all CPUs.
- R7: A request presented while busy_o is high is ignored and does not alter the scan in progress.
- R8: When the scan reaches the last CPU with list bits still set, it ends anyway and those bits are dropped.
- R9: busy_o rises on the cycle after acceptance and stays high until the scan ends. done_o is then high for exactly one cycle, the first cycle with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; accepted when idle |
| req_word_i | input | 64 | Request word |
| req_src_i | input | clog2(NUM_CPUS) | Index of the requesting CPU |
| cpu_aff_i | input | NUM_CPUS*24 | Affinity of each CPU, CPU k at [24k+23:24k] |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when the scan ends |
| set_valid_o | output | 1 | Set-pending strobe for the CPU on set_cpu_o |
| set_cpu_o | output | clog2(NUM_CPUS) | CPU index being visited |
| set_sgi_o | output | 4 | SGI number to mark pending |

## Verification
Directed requests cover the following cases:
- a single targeted hit deep in the index range, which shows the early stop;
- a zero list, which yields a one-cycle scan with no strobe;
- a nonzero level-3 field, which must miss every CPU;
- a list with an unreachable bit, which shows that leftovers are dropped at the last CPU;
- a broadcast with an empty list, which shows that the list has no say and that the requester is skipped.

Random words, biased so that the affinity fields often match the CPU table, mix both modes and both requester positions. The table contains a CPU whose level-0 value lies outside the low group, so a list bit can be consumed at a high index. Some requests inject a junk request during the scan; the per-cycle strobe pattern must stay equal to the model's, and no further scan may start after done.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int unsigned AFF_LVL_W = 8;
   localparam int unsigned AFF_W     = 3 * AFF_LVL_W;
   localparam int unsigned LIST_W    = 16;
   localparam int unsigned SGI_W     = 4;

   typedef struct packed {
      logic [SGI_W-1:0]     sgi;
      logic                 bcast;
      logic [LIST_W-1:0]    tlist;
      logic [AFF_LVL_W-1:0] lv1;
      logic [AFF_LVL_W-1:0] lv2;
      logic [AFF_LVL_W-1:0] lv3;
   } sgi_req_t;

   // Field positions of the request word
   function automatic sgi_req_t decode_req(input logic [63:0] w);
      sgi_req_t r;
      r.sgi   = w[27:24];
      r.bcast = w[40];
      r.tlist = w[15:0];
      r.lv1   = w[23:16];
      r.lv2   = w[39:32];
      r.lv3   = w[55:48];
      return r;
   endfunction

   // Targeted-mode hit test of one CPU affinity against the live list
   function automatic logic aff_hit(input sgi_req_t r, input logic [LIST_W-1:0] live,
                                    input logic [AFF_W-1:0] aff);
      return (r.lv3 == '0) && (aff[23:16] == r.lv2) && (aff[15:8] == r.lv1)
             && (aff[7:4] == 4'h0) && live[aff[3:0]];
   endfunction
endpackage

// File: rtl/sgi_target_select.sv
module sgi_target_select
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPUS  = 8,
   parameter bit          PAR_MATCH = 1'b0,
   localparam int unsigned IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  sgi_req_t                  req_i,
   input  logic [LIST_W-1:0]         live_i,
   input  logic [IDX_W-1:0]          src_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [NUM_CPUS*AFF_W-1:0] aff_i,
   output logic                      hit_o,
   output logic [LIST_W-1:0]         clr_o
);
   logic [AFF_W-1:0] cur_aff;
   logic             thit;

   assign cur_aff = aff_i[32'(idx_i)*AFF_W +: AFF_W];

   generate
      if (PAR_MATCH) begin : g_par
         // One comparator per CPU, result picked by the scan index
         logic [NUM_CPUS-1:0] hv;
         for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cmp
            assign hv[c] = aff_hit(req_i, live_i, aff_i[c*AFF_W +: AFF_W]);
         end
         assign thit = hv[idx_i];
      end else begin : g_mux
         // One shared comparator fed by the affinity mux
         assign thit = aff_hit(req_i, live_i, cur_aff);
      end
   endgenerate

   always_comb begin
      if (req_i.bcast) begin
         hit_o = (idx_i != src_i);
         clr_o = '0;
      end else begin
         hit_o = thit;
         clr_o = thit ? (LIST_W'(1) << cur_aff[3:0]) : '0;
      end
   end
endmodule

// File: rtl/sgi_scan_ctrl.sv
module sgi_scan_ctrl
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 8,
   localparam int unsigned IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPUS - 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  sgi_req_t          req_i,
   input  logic [IDX_W-1:0]  src_i,
   input  logic [LIST_W-1:0] clr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [LIST_W-1:0] live_o,
   output sgi_req_t          req_q_o,
   output logic [IDX_W-1:0]  src_q_o
);
   logic [LIST_W-1:0] live_nxt;
   logic              stop;

   assign live_nxt = live_o & ~clr_i;
   assign stop     = (!req_q_o.bcast && (live_nxt == '0)) || (idx_o == LAST_IDX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         idx_o   <= '0;
         live_o  <= '0;
         req_q_o <= '0;
         src_q_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               busy_o  <= 1'b1;
               idx_o   <= '0;
               req_q_o <= req_i;
               live_o  <= req_i.tlist;
               src_q_o <= src_i;
            end
         end else begin
            live_o <= live_nxt;
            if (stop) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPUS  = 8,
   parameter bit          PAR_MATCH = 1'b0,
   localparam int unsigned IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      req_valid_i,
   input  logic [63:0]               req_word_i,
   input  logic [IDX_W-1:0]          req_src_i,
   input  logic [NUM_CPUS*AFF_W-1:0] cpu_aff_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      set_valid_o,
   output logic [IDX_W-1:0]          set_cpu_o,
   output logic [SGI_W-1:0]          set_sgi_o
);
   generate
      if (NUM_CPUS < 1 || NUM_CPUS > LIST_W) begin : g_bad_cfg
         $error("sgi_dispatch: NUM_CPUS must lie in 1..16");
      end
   endgenerate

   sgi_req_t          req_q;
   logic [LIST_W-1:0] live;
   logic [LIST_W-1:0] clr;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  src_q;
   logic              hit;

   sgi_scan_ctrl #(.NUM_CPUS(NUM_CPUS)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (req_valid_i),
      .req_i   (decode_req(req_word_i)),
      .src_i   (req_src_i),
      .clr_i   (clr),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .idx_o   (idx),
      .live_o  (live),
      .req_q_o (req_q),
      .src_q_o (src_q)
   );

   sgi_target_select #(.NUM_CPUS(NUM_CPUS), .PAR_MATCH(PAR_MATCH)) u_sel (
      .req_i  (req_q),
      .live_i (live),
      .src_i  (src_q),
      .idx_i  (idx),
      .aff_i  (cpu_aff_i),
      .hit_o  (hit),
      .clr_o  (clr)
   );

   assign set_valid_o = busy_o & hit;
   assign set_cpu_o   = idx;
   assign set_sgi_o   = req_q.sgi;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
   parameter int unsigned NUM_CPUS = 8,
   localparam int unsigned IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             busy_o,
   input logic             done_o,
   input logic             set_valid_o,
   input logic [IDX_W-1:0] set_cpu_o,
   input logic [3:0]       set_sgi_o
);
   // R9: the end of a scan is flagged by done
   a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);
   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R9: done never overlaps a scan
   a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);
   // R4: strobes only during a scan
   a_r4_strobe_in_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_valid_o |-> busy_o);
   // R4: scan starts at CPU 0
   a_r4_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (set_cpu_o == '0));
   // R4: one CPU per cycle in index order
   a_r4_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> (set_cpu_o == IDX_W'($past(set_cpu_o) + 1'b1)));
   // R7: SGI number held for the whole scan
   a_r7_sgi_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> $stable(set_sgi_o));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .set_valid_o (set_valid_o),
   .set_cpu_o   (set_cpu_o),
   .set_sgi_o   (set_sgi_o)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
   localparam int N = 8;
   localparam int IW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [63:0]     req_word = '0;
   logic [IW-1:0]   req_src = '0;
   logic [N*24-1:0] cpu_aff;
   logic            busy, done, set_valid;
   logic [IW-1:0]   set_cpu;
   logic [3:0]      set_sgi;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;
   logic [23:0] aff_tab [N];

   always #4 clk = ~clk;

   sgi_dispatch #(.NUM_CPUS(N)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_word_i(req_word),
      .req_src_i(req_src), .cpu_aff_i(cpu_aff), .busy_o(busy), .done_o(done),
      .set_valid_o(set_valid), .set_cpu_o(set_cpu), .set_sgi_o(set_sgi));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference model: hits per visited index and number of visited cycles
   function automatic int model(input logic [63:0] w, input int src, output bit hits [N]);
      logic [15:0] live = w[15:0];
      bit bc = w[40];
      int v = 0;
      for (int k = 0; k < N; k++) hits[k] = 0;
      for (int k = 0; k < N; k++) begin
         v++;
         if (bc) hits[k] = (k != src);
         else if (w[55:48] == 0 && aff_tab[k][23:16] == w[39:32] && aff_tab[k][15:8] == w[23:16]
                  && aff_tab[k][7:4] == 0 && live[aff_tab[k][3:0]]) begin
            hits[k] = 1;
            live[aff_tab[k][3:0]] = 1'b0;
         end
         if (!bc && live == 0) break;
      end
      return v;
   endfunction

   task automatic run_req(input logic [63:0] w, input int src, input bit inject, input string tag);
      bit hits [N];
      int v = model(w, src, hits);
      @(negedge clk);
      req_valid = 1'b1; req_word = w; req_src = IW'(src);
      for (int c = 0; c < v; c++) begin
         @(negedge clk);
         if (c == 0 && inject) begin
            req_valid = 1'b1; req_word = ~w; req_src = IW'(src + 1);
         end else req_valid = 1'b0;
         check(busy == 1'b1, "R9 busy during scan", busy, 1);
         check(set_valid == hits[c], tag, set_valid, hits[c]);
         check(set_cpu == IW'(c), "R4 visit order", set_cpu, c);
         if (hits[c]) check(set_sgi == w[27:24], "R2 sgi field", set_sgi, w[27:24]);
      end
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b0 && done == 1'b1, "R5 R8 scan end cycle", {busy, done}, 2'b01);
      @(negedge clk);
      check(done == 1'b0, "R9 done single cycle", done, 0);
      if (inject) check(busy == 1'b0, "R7 busy request ignored", busy, 0);
   endtask

   initial begin
      for (int k = 0; k < N; k++) begin
         aff_tab[k] = {8'h00, 8'(k / 4), 8'(k % 4)};
      end
      aff_tab[6] = {8'h00, 8'h01, 8'h09};
      for (int k = 0; k < N; k++) cpu_aff[k*24 +: 24] = aff_tab[k];
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && set_valid == 0, "R1 reset state",
            {busy, done, set_valid}, 0);
      rst_n = 1'b1;
      // R3/R5: single deep hit with early stop (cpu 5)
      run_req(64'h0000_0000_0A01_0002, 0, 0, "R3 R5 single target");
      // R6: broadcast with empty list skips requester 3
      run_req(64'h0000_0100_0700_0000, 3, 0, "R6 broadcast");
      // R5: empty list ends after one cycle
      run_req(64'h0000_0000_0300_0000, 1, 0, "R5 empty list");
      // R8: unreachable bit 15 kept until the last CPU
      run_req(64'h0000_0000_0500_8001, 2, 0, "R8 leftover dropped");
      // R3: nonzero level 3 misses all
      run_req(64'h0001_0000_0200_FFFF, 2, 0, "R3 level3 miss");
      // R7: junk request during a scan
      run_req(64'h0000_0000_0C00_000C, 0, 1, "R7 targeted with injection");
      run_req(64'h0000_0100_0D00_0000, 7, 1, "R6 R7 broadcast with injection");
      void'($urandom(32'd1234));
      for (int i = 0; i < 150; i++) begin
         logic [63:0] w = {$urandom, $urandom};
         if ($urandom_range(0, 3) != 0) begin
            w[55:48] = ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00;
            w[39:32] = 8'h00;
            w[23:16] = 8'($urandom_range(0, 1));
         end
         run_req(w, $urandom_range(0, N - 1), ($urandom_range(0, 4) == 0),
                 w[40] ? "R6 random broadcast" : "R3 random targeted");
      end
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nerr++; nchk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule